// File: doc/BRIEF.md
# Decimating FIR Filter with Selectable Coefficient Bank

This block is a real-valued FIR filter that also decimates. It produces one filtered word for every M accepted input samples. Each input sample that arrives with its valid strobe goes into a 256-entry circular data RAM. The coefficients sit in a separate 256-entry coefficient RAM. A single multiply-accumulate unit works through the taps, one per clock. There is no symmetry folding, so every tap reads its own coefficient entry.

Three run-time inputs control the filter:
- the decimation factor minus one;
- the tap count minus one;
- a base offset into the coefficient RAM.

Several filters can be stored side by side in the coefficient RAM. Changing the base offset switches between them without reloading anything. Both RAMs are loaded through one address/data port, and its address advances by one after each write. Neither RAM is cleared by reset, so software preloads the data RAM with zeros to avoid a start-up transient. Each result is held in an output register until the next decimation boundary. As a result, the first word after reset is always zero.

Top module: `dfir_top`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `out_valid` is 0, `out_data` is 0 and `overrun` is 0.
- R2: A decimation counter counts accepted samples (`in_valid`=1). After reset, the sample that brings the count to `cfg_decim_m1`+1 is a boundary, and the count then restarts. `out_valid` is high for exactly the one cycle after the clock edge that accepted the boundary sample, and is low at all other times.
- R3: Take the sample accepted at a boundary as x[0] and earlier samples as x[k], with N = `cfg_last_tap`+1. The filter result is the sum over k = 0..N-1 of coef[(base+k) mod 256] times x[k], with both operands signed. The word presented at a boundary is the result started at the previous boundary. The first word after reset is therefore 0.
- R4: The sum is accumulated exactly in DW+CW+8 bits. `out_data` carries its low OW bits, so larger sums wrap.
- R5: The coefficient address (base+k) wraps modulo 256.
- R6: The base offset and tap count are captured at each boundary. Changing them selects a different stored filter from the next boundary onward, with no coefficient reload.
- R7: A result needs N clocks after its boundary. If another boundary arrives within those N clocks, the in-progress result is discarded, a new one starts, and `overrun` goes to 1. `overrun` then stays at 1 until reset.
- R8: When `mem_addr_load`=1, the write address becomes `mem_addr`. Every write with `mem_wr`=1 goes to the current address, and the address then increments modulo 256. If load and write happen in the same cycle, the write goes to the loaded address. `mem_tgt`=0 selects the coefficient RAM and `mem_tgt`=1 selects the data RAM.
- R9: Neither RAM is cleared by reset. After reset, accepted samples are stored at data addresses 0, 1, 2 and onward, and tap k of a boundary reads data address (newest − k) mod 256. Values preloaded through the port at those addresses therefore act as earlier history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_decim_m1 | input | 8 | Decimation factor minus one (use up to 31) |
| cfg_last_tap | input | 8 | Tap count minus one |
| cfg_coef_base | input | 8 | Coefficient RAM base offset of the active filter |
| mem_addr_load | input | 1 | Load `mem_addr` into the write address |
| mem_addr | input | 8 | Write address to load |
| mem_wr | input | 1 | Write strobe; address advances by one |
| mem_tgt | input | 1 | 0 = coefficient RAM, 1 = data RAM |
| mem_wdata | input | 16 | Write data (signed) |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample (signed) |
| out_valid | output | 1 | One-cycle output strobe per decimation boundary |
| out_data | output | 24 | Filtered word (signed, truncated) |
| overrun | output | 1 | Sticky flag: boundary arrived before taps finished |

## Verification
The hardest state to reach is a boundary that lands while the tap sequencer is still running. This includes the boundary that arrives on the very clock where the last tap would have retired. The stimulus reaches it by using a long filter with a decimation factor of one and back-to-back samples, after earlier phases have used wide gaps. A second hard case is reading history that no sample ever wrote. It is reached by resetting and writing one data-RAM entry just below address 0 through the port, then running a two-tap filter whose second tap must read that entry. Coefficient wrap is forced by placing a filter across address 255.

// File: rtl/dfir_pkg.sv
package dfir_pkg;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mac_st_e;

    typedef enum logic {
        TGT_COEF = 1'b0,
        TGT_DATA = 1'b1
    } mem_tgt_e;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] last_tap;
        logic [AW-1:0] newest;
    } job_t;

    function automatic logic [AW-1:0] coef_slot(input logic [AW-1:0] base,
                                                input logic [AW-1:0] tap);
        return base + tap;
    endfunction

    function automatic logic [AW-1:0] hist_slot(input logic [AW-1:0] newest,
                                                input logic [AW-1:0] tap);
        return newest - tap;
    endfunction

endpackage

// File: rtl/dfir_ram.sv
module dfir_ram
    import dfir_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic signed [W-1:0] wdata,
    input  logic [AW-1:0]       raddr,
    output logic signed [W-1:0] rdata
);
    logic signed [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dfir_wrport.sv
module dfir_wrport
    import dfir_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_in,
    input  logic          wr,
    input  mem_tgt_e      tgt,
    output logic [AW-1:0] wr_addr,
    output logic          coef_we,
    output logic          data_we
);
    logic [AW-1:0] ptr;

    assign wr_addr = addr_load ? addr_in : ptr;
    assign coef_we = wr && (tgt == TGT_COEF);
    assign data_we = wr && (tgt == TGT_DATA);

    always_ff @(posedge clk) begin
        if (rst)     ptr <= '0;
        else if (wr) ptr <= wr_addr + 1'b1;
        else         ptr <= wr_addr;
    end

    assert_addr_step_R8: assert property (@(posedge clk) disable iff (rst)
        (wr && !addr_load) |=> (ptr == AW'($past(ptr) + 1'b1)));
endmodule

// File: rtl/dfir_insq.sv
module dfir_insq
    import dfir_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [AW-1:0] decim_m1,
    output logic [AW-1:0] wptr,
    output logic          start
);
    logic [AW-1:0] cnt;

    assign start = in_valid && (cnt >= decim_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            wptr <= '0;
        end else if (in_valid) begin
            wptr <= wptr + 1'b1;
            cnt  <= start ? '0 : cnt + 1'b1;
        end
    end

    assert_start_needs_sample_R2: assert property (@(posedge clk) disable iff (rst)
        start |-> in_valid);
    assert_ring_advance_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (wptr == AW'($past(wptr) + 1'b1)));
endmodule

// File: rtl/dfir_mac.sv
module dfir_mac
    import dfir_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int OW    = 24,
    parameter int ACC_W = DW + CW + AW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [AW-1:0]        cfg_base,
    input  logic [AW-1:0]        cfg_last_tap,
    input  logic [AW-1:0]        newest,
    input  logic signed [CW-1:0] coef_q,
    input  logic signed [DW-1:0] data_q,
    output logic [AW-1:0]        coef_ra,
    output logic [AW-1:0]        data_ra,
    output logic                 out_valid,
    output logic [OW-1:0]        out_data,
    output logic                 overrun
);
    localparam int PW = DW + CW;

    mac_st_e                 st;
    job_t                    job;
    logic [AW-1:0]           tap;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] result;
    logic signed [ACC_W-1:0] acc_nxt;
    logic signed [PW-1:0]    prod;

    assign coef_ra = coef_slot(job.base, tap);
    assign data_ra = hist_slot(job.newest, tap);

    always_comb begin
        prod    = coef_q * data_q;
        acc_nxt = acc + {{(ACC_W-PW){prod[PW-1]}}, prod};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            job       <= '0;
            tap       <= '0;
            acc       <= '0;
            result    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            overrun   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (start) begin
                out_valid <= 1'b1;
                out_data  <= result[OW-1:0];
                if (st == ST_RUN) overrun <= 1'b1;
                st       <= ST_RUN;
                tap      <= '0;
                acc      <= '0;
                job.base     <= cfg_base;
                job.last_tap <= cfg_last_tap;
                job.newest   <= newest;
            end else if (st == ST_RUN) begin
                acc <= acc_nxt;
                if (tap == job.last_tap) begin
                    st     <= ST_IDLE;
                    result <= acc_nxt;
                end else begin
                    tap <= tap + 1'b1;
                end
            end
        end
    end

    assert_tap_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |-> (tap <= job.last_tap));
    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
    assert_result_held_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !start) |=> $stable(result));
    assert_strobe_follows_start_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(start));
endmodule

// File: rtl/dfir_top.sv
module dfir_top
    import dfir_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int OW = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        cfg_decim_m1,
    input  logic [AW-1:0]        cfg_last_tap,
    input  logic [AW-1:0]        cfg_coef_base,
    input  logic                 mem_addr_load,
    input  logic [AW-1:0]        mem_addr,
    input  logic                 mem_wr,
    input  logic                 mem_tgt,
    input  logic signed [DW-1:0] mem_wdata,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic [OW-1:0]        out_data,
    output logic                 overrun
);
    localparam int ACC_W = DW + CW + AW;

    logic [AW-1:0]        port_addr;
    logic                 port_coef_we;
    logic                 port_data_we;
    logic [AW-1:0]        wptr;
    logic                 start;
    logic [AW-1:0]        coef_ra;
    logic [AW-1:0]        data_ra;
    logic signed [CW-1:0] coef_q;
    logic signed [DW-1:0] data_q;
    logic                 dram_we;
    logic [AW-1:0]        dram_wa;
    logic signed [DW-1:0] dram_wd;

    dfir_wrport u_wrport (
        .clk       (clk),
        .rst       (rst),
        .addr_load (mem_addr_load),
        .addr_in   (mem_addr),
        .wr        (mem_wr),
        .tgt       (mem_tgt_e'(mem_tgt)),
        .wr_addr   (port_addr),
        .coef_we   (port_coef_we),
        .data_we   (port_data_we)
    );

    dfir_insq u_insq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .decim_m1 (cfg_decim_m1),
        .wptr     (wptr),
        .start    (start)
    );

    // sample stream has priority over port writes into the history RAM
    assign dram_we = in_valid || port_data_we;
    assign dram_wa = in_valid ? wptr : port_addr;
    assign dram_wd = in_valid ? in_data : mem_wdata;

    dfir_ram #(.W(CW)) u_coef_ram (
        .clk   (clk),
        .we    (port_coef_we),
        .waddr (port_addr),
        .wdata (CW'(mem_wdata)),
        .raddr (coef_ra),
        .rdata (coef_q)
    );

    dfir_ram #(.W(DW)) u_data_ram (
        .clk   (clk),
        .we    (dram_we),
        .waddr (dram_wa),
        .wdata (dram_wd),
        .raddr (data_ra),
        .rdata (data_q)
    );

    dfir_mac #(.DW(DW), .CW(CW), .OW(OW), .ACC_W(ACC_W)) u_mac (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cfg_base     (cfg_coef_base),
        .cfg_last_tap (cfg_last_tap),
        .newest       (wptr),
        .coef_q       (coef_q),
        .data_q       (data_q),
        .coef_ra      (coef_ra),
        .data_ra      (data_ra),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .overrun      (overrun)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !overrun && out_data == '0));
    assert_valid_needs_input_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
endmodule

// File: tb/sim_dfir_top.sv
module sim_dfir_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_decim_m1 = '0;
    logic [7:0]  cfg_last_tap = '0;
    logic [7:0]  cfg_coef_base = '0;
    logic        mem_addr_load = 1'b0;
    logic [7:0]  mem_addr = '0;
    logic        mem_wr = 1'b0;
    logic        mem_tgt = 1'b0;
    logic signed [15:0] mem_wdata = '0;
    logic        in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic        out_valid;
    logic [23:0] out_data;
    logic        overrun;

    always #5 clk = ~clk;

    dfir_top u0 (
        .clk(clk), .rst(rst), .cfg_decim_m1(cfg_decim_m1), .cfg_last_tap(cfg_last_tap),
        .cfg_coef_base(cfg_coef_base), .mem_addr_load(mem_addr_load), .mem_addr(mem_addr),
        .mem_wr(mem_wr), .mem_tgt(mem_tgt), .mem_wdata(mem_wdata), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    int    cram [256];
    int    dram [256];
    int    m_wp = 0, m_mp = 0, m_cnt = 0;
    longint m_res = 0, m_pend = 0;
    int    m_edge = 0, m_fin = 0;
    bit    m_active = 0, e_valid = 0, e_ovr = 0;
    longint e_out = 0;

    task automatic model_edge();
        int eff;
        bit bnd;
        longint s;
        m_edge++;
        if (rst) begin
            m_wp = 0; m_mp = 0; m_cnt = 0; m_res = 0; m_active = 0;
            e_valid = 0; e_out = 0; e_ovr = 0;
            return;
        end
        eff = mem_addr_load ? int'(mem_addr) : m_mp;
        if (mem_wr) begin
            if (!mem_tgt) cram[eff] = int'(mem_wdata);
            else if (!in_valid) dram[eff] = int'(mem_wdata);
        end
        m_mp = mem_wr ? (eff + 1) % 256 : eff;
        bnd = 0;
        e_valid = 0;
        if (in_valid) begin
            dram[m_wp] = int'(in_data);
            if (m_cnt >= int'(cfg_decim_m1)) begin bnd = 1; m_cnt = 0; end
            else m_cnt++;
        end
        if (bnd) begin
            e_valid = 1;
            e_out = m_res;
            if (m_active && m_edge <= m_fin) e_ovr = 1;  // R7
            s = 0;
            for (int k = 0; k <= int'(cfg_last_tap); k++)
                s += longint'(cram[(int'(cfg_coef_base) + k) % 256]) *
                     longint'(dram[(m_wp - k + 256) % 256]);
            m_pend = s;
            m_fin = m_edge + int'(cfg_last_tap) + 1;
            m_active = 1;
        end else if (m_active && m_edge == m_fin) begin
            m_res = m_pend;
            m_active = 0;
        end
        if (in_valid) m_wp = (m_wp + 1) % 256;
    endtask

    task automatic compare();
        logic [23:0] exp24;
        exp24 = e_out[23:0];
        checks++;
        if (out_valid !== e_valid) begin
            errors++;
            $display("FAIL %s out_valid got %0b exp %0b (cycle %0d)", tag, out_valid, e_valid, m_edge);
        end
        checks++;
        if (out_data !== exp24) begin
            errors++;
            $display("FAIL %s out_data got %0d exp %0d (cycle %0d)", tag, $signed(out_data), $signed(exp24), m_edge);
        end
        checks++;
        if (overrun !== e_ovr) begin
            errors++;
            $display("FAIL %s overrun got %0b exp %0b (cycle %0d)", tag, overrun, e_ovr, m_edge);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic mem_load(input bit tgt, input int addr);
        mem_tgt = tgt; mem_addr_load = 1; mem_addr = 8'(addr); mem_wr = 0;
        step();
        mem_addr_load = 0;
    endtask

    task automatic mem_put(input int val);
        mem_wr = 1; mem_wdata = 16'(val);
        step();
        mem_wr = 0;
    endtask

    task automatic feed(input int val, input int gap);
        in_valid = 1; in_data = 16'(val);
        step();
        in_valid = 0;
        for (int g = 0; g < gap; g++) step();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin cram[i] = 0; dram[i] = 0; end
        // R1: reset state
        tag = "R1";
        for (int i = 0; i < 3; i++) step();
        rst = 0;
        step();

        // R8: zero history then load three filters via auto-increment
        tag = "R8";
        mem_load(1, 0);
        for (int i = 0; i < 256; i++) mem_put(0);
        mem_load(0, 4);
        mem_put(1); mem_put(2); mem_put(3); mem_put(4);
        mem_load(0, 100);
        mem_put(5); mem_put(-1); mem_put(7);
        mem_load(0, 253);
        mem_put(10); mem_put(20); mem_put(30); mem_put(40);
        mem_load(0, 120);
        mem_put(30000); mem_put(30000);
        // load and write in the same cycle goes to the loaded address (R8)
        mem_tgt = 0; mem_addr_load = 1; mem_addr = 8'd200; mem_wr = 1; mem_wdata = 16'sd9;
        step();
        mem_addr_load = 0; mem_wr = 0;

        // R3: decimate by 3, four taps at base 4; first output is zero
        tag = "R3";
        cfg_decim_m1 = 8'd2; cfg_last_tap = 8'd3; cfg_coef_base = 8'd4;
        for (int i = 1; i <= 15; i++) feed(i * 3 - 20, 2);

        // R6: switch to the filter at base 100 with three taps, no reload
        tag = "R6";
        cfg_coef_base = 8'd100; cfg_last_tap = 8'd2;
        for (int i = 0; i < 12; i++) feed(7 - i * 5, 2);

        // R5: filter straddling address 255 (253,254,255,0)
        tag = "R5";
        cfg_coef_base = 8'd253; cfg_last_tap = 8'd3; cfg_decim_m1 = 8'd1;
        for (int i = 0; i < 10; i++) feed(i * 11 - 40, 3);

        // R4: large products wrap in the output width
        tag = "R4";
        cfg_coef_base = 8'd120; cfg_last_tap = 8'd1; cfg_decim_m1 = 8'd0;
        for (int i = 0; i < 6; i++) feed(30000 - i, 3);

        // R2: decimation by one, single tap, outputs on consecutive samples
        tag = "R2";
        cfg_coef_base = 8'd200; cfg_last_tap = 8'd0;
        for (int i = 0; i < 8; i++) feed(i - 3, 1);
        for (int i = 0; i < 4; i++) feed(i + 50, 0);
        step(); step();

        // R7: eight taps with back-to-back boundaries raise the sticky flag
        tag = "R7";
        cfg_coef_base = 8'd0; cfg_last_tap = 8'd7;
        for (int i = 0; i < 6; i++) feed(i + 1, 0);
        for (int i = 0; i < 4; i++) feed(i, 12);

        // R9: reset keeps RAM contents; preloaded history at address 255
        tag = "R9";
        rst = 1; step(); step();
        rst = 0; step();
        mem_load(1, 255);
        mem_put(7);
        cfg_coef_base = 8'd4; cfg_last_tap = 8'd1; cfg_decim_m1 = 8'd0;
        feed(3, 4);   // result 1*3 + 2*7 = 17, presented at next boundary
        feed(1, 4);
        checks++;
        if (overrun !== 1'b0) begin
            errors++;
            $display("FAIL R9 overrun after reset got %0b exp 0", overrun);
        end
        feed(0, 4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog expired got hung exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule